// File: doc/BRIEF.md
# Digital Compare Trip Event Generator

This block turns raw trip signals into qualified trip events for a pair of PWM output channels (channel 0 drives output A, channel 1 drives output B). Each channel picks two of the incoming trip lines, one as its low input and one as its high input. It then tests two configurable pattern conditions on that pair. The first condition raises a one-shot event. The one-shot event sets a latch that only an explicit clear strobe can reset. The second condition raises a per-cycle event. The per-cycle event sets a latch that clears by itself at the PWM counter-zero strobe, once the condition has gone away.

The raw events are combinational, so an action qualifier can use them directly without waiting for a clock. The block also overrides each channel's PWM signal while a trip is active. The override can drive the output low, drive it high, invert it, or leave it alone. Setting both override actions to "no change" leaves the PWM path untouched. The events then serve only as set/reset sources for a downstream action qualifier, for example to build a hysteresis current loop.

Top module: `dc_trip_gen`

## Requirements
- R1: Each channel takes its low input from `trip_i[lo_sel]` and its high input from `trip_i[hi_sel]`, using its own 3-bit index fields in `lo_sel_i` and `hi_sel_i` (channel c uses bits [3c+2:3c]).
- R2: The 3-bit condition code is decoded as follows. 0 means off. 1 means low input is 0. 2 means low input is 1. 3 means high input is 0. 4 means high input is 1. 5 means low input is 1 and high input is 0. Codes 6 and 7 behave as off.
- R3: `ost_evt_o` and `cbc_evt_o` follow the trip inputs and configuration combinationally, in the same cycle and with no register.
- R4: A one-shot event sets `ost_flag_o` at the next clock edge. The flag then stays set after the event goes away, until a clear strobe arrives.
- R5: A clear strobe on `ost_clr_i` resets the one-shot flag at the next edge only when the one-shot event is inactive. If the event is active in the same cycle, the set wins.
- R6: A per-cycle event sets `cbc_flag_o` at the next edge. The flag clears at an edge where `zero_i` is high and the per-cycle event is inactive. Without `zero_i` it holds.
- R7: The 2-bit action code is decoded as follows. 0 means no change. 1 means force low. 2 means force high. 3 means invert `pwm_i`. A one-shot trip with a non-zero action takes priority over a per-cycle trip.
- R8: A channel counts as tripped while its event is present or its flag is set. The override applies combinationally from the moment the event appears. When the channel is not tripped, `pwm_o` equals `pwm_i`.
- R9: A channel's events, flags and override affect only that channel's own output.
- R10: After reset, both flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_i | input | NUM_TRIPS | Trip signal lines |
| zero_i | input | 1 | PWM counter-zero strobe |
| ost_clr_i | input | NUM_CH | Per-channel one-shot clear strobe |
| lo_sel_i | input | NUM_CH*SEL_W | Low input index per channel |
| hi_sel_i | input | NUM_CH*SEL_W | High input index per channel |
| ost_cond_i | input | NUM_CH*3 | One-shot condition code per channel |
| cbc_cond_i | input | NUM_CH*3 | Per-cycle condition code per channel |
| ost_act_i | input | NUM_CH*2 | One-shot output action per channel |
| cbc_act_i | input | NUM_CH*2 | Per-cycle output action per channel |
| pwm_i | input | NUM_CH | Incoming PWM signal per channel |
| ost_evt_o | output | NUM_CH | Raw one-shot event |
| cbc_evt_o | output | NUM_CH | Raw per-cycle event |
| ost_flag_o | output | NUM_CH | Latched one-shot flag |
| cbc_flag_o | output | NUM_CH | Latched per-cycle flag |
| pwm_o | output | NUM_CH | PWM signal after trip override |

## Verification
The hardest cases to reach are the ones where a release strobe collides with a live condition. These are a one-shot clear arriving while the one-shot event is still present, and a counter-zero strobe arriving while the per-cycle event is still present. In both cases the flag must survive. The bench holds the selected trip line high, pulses the strobe for exactly one edge, and checks that the flag is still set. It then drops the trip line and checks that the flag stays set until a later strobe with the condition gone clears it. Condition codes are swept through a table of input patterns, and the override is checked before the clock edge to show that it takes effect immediately.

// File: rtl/dc_trip_pkg.sv
package dc_trip_pkg;

  typedef enum logic [2:0] {
    COND_OFF     = 3'd0,
    COND_LO_LOW  = 3'd1,
    COND_LO_HIGH = 3'd2,
    COND_HI_LOW  = 3'd3,
    COND_HI_HIGH = 3'd4,
    COND_LO_ONLY = 3'd5
  } cond_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_INVERT = 2'd3
  } act_e;

  function automatic logic cond_hit(logic [2:0] code, logic lo, logic hi);
    case (code)
      COND_LO_LOW:  return !lo;
      COND_LO_HIGH: return lo;
      COND_HI_LOW:  return !hi;
      COND_HI_HIGH: return hi;
      COND_LO_ONLY: return lo && !hi;
      default:      return 1'b0;
    endcase
  endfunction

  function automatic logic apply_act(logic [1:0] act, logic pwm);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_INVERT: return !pwm;
      default:    return pwm;
    endcase
  endfunction

endpackage

// File: rtl/dc_cond_eval.sv
module dc_cond_eval
  import dc_trip_pkg::*;
#(
  parameter int NUM_TRIPS = 8,
  localparam int SEL_W = $clog2(NUM_TRIPS)
) (
  input  logic [NUM_TRIPS-1:0] trip_i,
  input  logic [SEL_W-1:0]     lo_sel_i,
  input  logic [SEL_W-1:0]     hi_sel_i,
  input  logic [2:0]           ost_cond_i,
  input  logic [2:0]           cbc_cond_i,
  output logic                 ost_evt_o,
  output logic                 cbc_evt_o
);
  logic lo_in, hi_in;

  assign lo_in     = trip_i[lo_sel_i];
  assign hi_in     = trip_i[hi_sel_i];
  assign ost_evt_o = cond_hit(ost_cond_i, lo_in, hi_in);
  assign cbc_evt_o = cond_hit(cbc_cond_i, lo_in, hi_in);
endmodule

// File: rtl/dc_trip_latch.sv
module dc_trip_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rel_i,
  output logic flag_o
);
  // set dominates release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (rel_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/dc_out_action.sv
module dc_out_action
  import dc_trip_pkg::*;
(
  input  logic       pwm_i,
  input  logic       ost_on_i,
  input  logic       cbc_on_i,
  input  logic [1:0] ost_act_i,
  input  logic [1:0] cbc_act_i,
  output logic       pwm_o
);
  always_comb begin
    pwm_o = pwm_i;
    if (ost_on_i && ost_act_i != ACT_NONE)
      pwm_o = apply_act(ost_act_i, pwm_i);
    else if (cbc_on_i && cbc_act_i != ACT_NONE)
      pwm_o = apply_act(cbc_act_i, pwm_i);
  end
endmodule

// File: rtl/dc_trip_gen.sv
module dc_trip_gen
  import dc_trip_pkg::*;
#(
  parameter int NUM_TRIPS = 8,
  parameter int NUM_CH    = 2,
  localparam int SEL_W    = $clog2(NUM_TRIPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_TRIPS-1:0]    trip_i,
  input  logic                    zero_i,
  input  logic [NUM_CH-1:0]       ost_clr_i,
  input  logic [NUM_CH*SEL_W-1:0] lo_sel_i,
  input  logic [NUM_CH*SEL_W-1:0] hi_sel_i,
  input  logic [NUM_CH*3-1:0]     ost_cond_i,
  input  logic [NUM_CH*3-1:0]     cbc_cond_i,
  input  logic [NUM_CH*2-1:0]     ost_act_i,
  input  logic [NUM_CH*2-1:0]     cbc_act_i,
  input  logic [NUM_CH-1:0]       pwm_i,
  output logic [NUM_CH-1:0]       ost_evt_o,
  output logic [NUM_CH-1:0]       cbc_evt_o,
  output logic [NUM_CH-1:0]       ost_flag_o,
  output logic [NUM_CH-1:0]       cbc_flag_o,
  output logic [NUM_CH-1:0]       pwm_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dc_cond_eval #(.NUM_TRIPS(NUM_TRIPS)) u_eval (
      .trip_i     (trip_i),
      .lo_sel_i   (lo_sel_i[c*SEL_W +: SEL_W]),
      .hi_sel_i   (hi_sel_i[c*SEL_W +: SEL_W]),
      .ost_cond_i (ost_cond_i[c*3 +: 3]),
      .cbc_cond_i (cbc_cond_i[c*3 +: 3]),
      .ost_evt_o  (ost_evt_o[c]),
      .cbc_evt_o  (cbc_evt_o[c])
    );

    dc_trip_latch u_ost (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ost_evt_o[c]),
      .rel_i  (ost_clr_i[c]),
      .flag_o (ost_flag_o[c])
    );

    dc_trip_latch u_cbc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (cbc_evt_o[c]),
      .rel_i  (zero_i),
      .flag_o (cbc_flag_o[c])
    );

    // event term makes the override take effect before the latch
    dc_out_action u_act (
      .pwm_i     (pwm_i[c]),
      .ost_on_i  (ost_evt_o[c] | ost_flag_o[c]),
      .cbc_on_i  (cbc_evt_o[c] | cbc_flag_o[c]),
      .ost_act_i (ost_act_i[c*2 +: 2]),
      .cbc_act_i (cbc_act_i[c*2 +: 2]),
      .pwm_o     (pwm_o[c])
    );
  end

endmodule

// File: rtl/dc_trip_gen_chk.sv
module dc_trip_gen_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              zero_i,
  input logic [NUM_CH-1:0] ost_clr_i,
  input logic [NUM_CH-1:0] pwm_i,
  input logic [NUM_CH-1:0] ost_evt_o,
  input logic [NUM_CH-1:0] cbc_evt_o,
  input logic [NUM_CH-1:0] ost_flag_o,
  input logic [NUM_CH-1:0] cbc_flag_o,
  input logic [NUM_CH-1:0] pwm_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4
    ost_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ost_evt_o[c] |=> ost_flag_o[c]);
    // R4
    ost_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ost_flag_o[c] && !ost_clr_i[c] |=> ost_flag_o[c]);
    // R5
    ost_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ost_clr_i[c] && !ost_evt_o[c] |=> !ost_flag_o[c]);
    // R6
    cbc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cbc_evt_o[c] |=> cbc_flag_o[c]);
    // R6
    cbc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cbc_flag_o[c] && !zero_i |=> cbc_flag_o[c]);
    // R6
    cbc_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_i && !cbc_evt_o[c] |=> !cbc_flag_o[c]);
    // R8
    idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ost_evt_o[c] && !cbc_evt_o[c] && !ost_flag_o[c] && !cbc_flag_o[c]
      |-> pwm_o[c] == pwm_i[c]);
  end
endmodule

bind dc_trip_gen dc_trip_gen_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .zero_i     (zero_i),
  .ost_clr_i  (ost_clr_i),
  .pwm_i      (pwm_i),
  .ost_evt_o  (ost_evt_o),
  .cbc_evt_o  (cbc_evt_o),
  .ost_flag_o (ost_flag_o),
  .cbc_flag_o (cbc_flag_o),
  .pwm_o      (pwm_o)
);

// File: tb/dc_trip_gen_test.sv
module dc_trip_gen_test;
  localparam int NT = 8;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] trip = '0;
  logic          zero = 1'b0;
  logic [1:0]    clr = '0;
  logic [5:0]    lo_sel = {3'd5, 3'd1};
  logic [5:0]    hi_sel = {3'd6, 3'd2};
  logic [5:0]    ost_cond = '0, cbc_cond = '0;
  logic [3:0]    ost_act = '0, cbc_act = '0;
  logic [1:0]    pwm_in = 2'b11;
  logic [1:0]    ost_evt, cbc_evt, ost_flag, cbc_flag, pwm_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dc_trip_gen #(.NUM_TRIPS(NT), .NUM_CH(NC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .trip_i(trip), .zero_i(zero),
    .ost_clr_i(clr), .lo_sel_i(lo_sel), .hi_sel_i(hi_sel),
    .ost_cond_i(ost_cond), .cbc_cond_i(cbc_cond),
    .ost_act_i(ost_act), .cbc_act_i(cbc_act), .pwm_i(pwm_in),
    .ost_evt_o(ost_evt), .cbc_evt_o(cbc_evt),
    .ost_flag_o(ost_flag), .cbc_flag_o(cbc_flag), .pwm_o(pwm_out)
  );

  // {cond[2:0], lo, hi, expected event}
  localparam logic [5:0] VEC [13] = '{
    {3'd0, 1'b1, 1'b0, 1'b0}, {3'd1, 1'b0, 1'b1, 1'b1}, {3'd1, 1'b1, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b1, 1'b1}, {3'd2, 1'b0, 1'b0, 1'b0}, {3'd3, 1'b0, 1'b0, 1'b1},
    {3'd3, 1'b1, 1'b1, 1'b0}, {3'd4, 1'b0, 1'b1, 1'b1}, {3'd4, 1'b1, 1'b0, 1'b0},
    {3'd5, 1'b1, 1'b0, 1'b1}, {3'd5, 1'b1, 1'b1, 1'b0}, {3'd5, 1'b0, 1'b0, 1'b0},
    {3'd6, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    chk("R10 ost flags", ost_flag, 2'b00);
    chk("R10 cbc flags", cbc_flag, 2'b00);
    rst_n = 1'b1;
    step();
    chk("R10 flags after release", {ost_flag, cbc_flag}, 4'b0);
    chk("R8 idle pass-through", pwm_out, 2'b11);

    // R2 condition table on channel 0, R3 same-cycle event
    for (int i = 0; i < 13; i++) begin
      ost_cond[2:0] = VEC[i][5:3];
      trip[1] = VEC[i][2];
      trip[2] = VEC[i][1];
      #1;
      chk($sformatf("R2 R3 vector %0d", i), ost_evt[0], VEC[i][0]);
      step();
    end
    ost_cond = '0;
    trip = '0;
    clr = 2'b01;
    step();
    clr = '0;
    chk("R5 clear idle", ost_flag[0], 1'b0);

    // R1 index selection
    ost_cond[2:0] = 3'd2;
    trip = 8'b0010_0000;
    #1 chk("R1 other channel line ignored", ost_evt[0], 1'b0);
    trip = 8'b0000_0010;
    #1 chk("R1 own low line", ost_evt[0], 1'b1);

    // R8 immediate override, R4 latch, R7 force low, R9 isolation
    ost_act[1:0] = 2'd1;
    #1 chk("R8 override before edge", pwm_out[0], 1'b0);
    chk("R8 flag not yet set", ost_flag[0], 1'b0);
    step();
    chk("R4 flag set", ost_flag[0], 1'b1);
    trip = '0;
    step();
    chk("R4 flag held", ost_flag[0], 1'b1);
    chk("R7 force low", pwm_out[0], 1'b0);
    chk("R9 other channel output", pwm_out[1], 1'b1);
    chk("R9 other channel flag", ost_flag[1], 1'b0);

    // R5 clear vs set
    trip[1] = 1'b1;
    clr = 2'b01;
    step();
    chk("R5 set wins over clear", ost_flag[0], 1'b1);
    trip = '0;
    step();
    clr = '0;
    chk("R5 clear wins when idle", ost_flag[0], 1'b0);
    chk("R8 released output", pwm_out[0], 1'b1);

    // R7 force high
    ost_act[1:0] = 2'd2;
    pwm_in = 2'b00;
    trip[1] = 1'b1;
    #1 chk("R7 force high", pwm_out[0], 1'b1);
    step();
    trip = '0;
    clr = 2'b01;
    step();
    clr = '0;
    ost_cond = '0;

    // R6 per-cycle latch, R7 invert
    cbc_cond[2:0] = 3'd5;
    cbc_act[1:0] = 2'd3;
    trip[1] = 1'b1;
    trip[2] = 1'b1;
    #1 chk("R2 both lines high", cbc_evt[0], 1'b0);
    trip[2] = 1'b0;
    step();
    chk("R6 cbc set", cbc_flag[0], 1'b1);
    pwm_in = 2'b01;
    #1 chk("R7 invert of 1", pwm_out[0], 1'b0);
    pwm_in = 2'b00;
    #1 chk("R7 invert of 0", pwm_out[0], 1'b1);
    zero = 1'b1;
    step();
    chk("R6 zero with condition present", cbc_flag[0], 1'b1);
    zero = 1'b0;
    trip = '0;
    step();
    chk("R6 hold without zero", cbc_flag[0], 1'b1);
    zero = 1'b1;
    step();
    zero = 1'b0;
    chk("R6 cleared at zero", cbc_flag[0], 1'b0);
    chk("R8 pass after cbc", pwm_out[0], 1'b0);

    // R7 one-shot priority
    ost_cond[2:0] = 3'd2;
    ost_act[1:0] = 2'd1;
    cbc_cond[2:0] = 3'd2;
    cbc_act[1:0] = 2'd2;
    pwm_in = 2'b01;
    trip[1] = 1'b1;
    #1 chk("R7 one-shot priority", pwm_out[0], 1'b0);
    step();
    trip = '0;
    clr = 2'b01;
    zero = 1'b1;
    step();
    clr = '0;
    zero = 1'b0;
    ost_cond = '0;
    cbc_cond = '0;
    chk("R5 R6 both cleared", {ost_flag[0], cbc_flag[0]}, 2'b00);

    // R9 channel 1 alone
    ost_cond[5:3] = 3'd4;
    ost_act[3:2] = 2'd2;
    pwm_in = 2'b00;
    trip[6] = 1'b1;
    #1 chk("R9 channel 1 override", pwm_out, 2'b10);
    step();
    chk("R9 channel 1 flag only", ost_flag, 2'b10);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule